// File: doc/BRIEF.md
# Duty-Programmable Clock Divider

This block derives a slower clock from one of two source clocks: a peripheral bus clock or a 48 MHz reference. A 4-bit divide value sets the period and a separate 4-bit compare value sets how long each period stays low. The high time is whatever remains of the period. The result is a single divided clock that feeds an output selector elsewhere on the chip.

A glitch-free switch picks the source, and every part of the divider runs on the chosen clock. A free-running counter steps through the period. Divide and compare settings are taken into the counter's working copy only when a period ends, or continuously while the divider is off. The output clock comes straight from a flop. A setting that cannot produce a valid waveform holds the output low and raises an error flag.

Top module: `clkdiv_duty`

## Requirements
- R1: After reset, the divided clock and the error flag are low, and the peripheral bus clock is the selected source.
- R2: While enabled with a compare value c smaller than the divide value d, the divided clock repeats with a period of d+1 cycles of the selected source.
- R3: In that case each period has the divided clock low for c+1 source cycles and then high for d−c source cycles. The output is registered, so it reflects the counter position one source cycle earlier.
- R4: The select input picks the source clock. Value 0 selects the peripheral bus clock and value 1 selects the 48 MHz clock. The switch between the two never produces a shortened pulse.
- R5: While the enable input is 0, the divided clock is held low and the period counter is held at zero, so the first period after enabling starts with a full low phase.
- R6: While enabled with the compare value equal to or larger than the divide value (including a divide value of 0), the divided clock stays low and the error flag is high. The error flag is low while the divider is off.
- R7: Changes to the divide or compare inputs while enabled take effect only at the end of the current period. A period already in progress keeps its length and duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Synchronous active-low reset |
| pclk_i | input | 1 | Peripheral bus clock, source 0 |
| fclk_i | input | 1 | 48 MHz clock, source 1 |
| en_i | input | 1 | Divider enable (1 = run) |
| sel_i | input | 1 | Source select (0 = pclk_i, 1 = fclk_i) |
| div_i | input | 4 | Divide value d; period is d+1 source cycles |
| cmp_i | input | 4 | Compare value c; low phase is c+1 source cycles |
| dclk_o | output | 1 | Divided, duty-programmed clock |
| cfg_err_o | output | 1 | High while enabled with c not smaller than d |

## Verification
The reference model advances on whichever source clock is selected. Any mix-up in the select polarity or the clock used therefore shows up as drift against the 48 MHz edges. The bench changes the divide and compare values in the middle of a period. A design that loads them immediately would cut the running period short or stretch it. The extremes are covered: d=15 with c=14 (a one-cycle high phase) and d=1 with c=0. So are the invalid cases c=d and d=0, where a design that skipped the validity test would toggle instead of holding low with the flag raised. The enable is dropped mid-period and raised again. A counter that resumed instead of restarting at zero would begin with a short low phase.

// File: rtl/clkdiv_pkg.sv
// Package: shared definitions for the duty-programmable clock divider.
// Assumes a 4-bit divide/compare field by default and a 1-bit source select.
package clkdiv_pkg;
    localparam int unsigned DEF_CNT_W = 4;
    localparam int unsigned DEF_SEL_W = 1;

    // Source clock identifiers; the numeric value is the select code.
    typedef enum logic [DEF_SEL_W-1:0] {
        SRC_PCLK = 1'b0,
        SRC_FCLK = 1'b1
    } src_e;
endpackage

// File: rtl/ckdiv_srcsel.sv
// Module: ckdiv_srcsel
// Glitch-free clock switch over NUM_SRC source clocks. A lane opens its gate
// only after every other gate has closed. The request passes two rising-edge
// flops and one falling-edge flop in the lane's own clock. The gate therefore
// changes only while that clock is low.
// Assumes: reset is held for several cycles of each source clock. Reset opens
// lane 0, so the downstream logic is clocked while it is being reset.
module ckdiv_srcsel #(
    parameter int unsigned SEL_W   = clkdiv_pkg::DEF_SEL_W,
    parameter int unsigned NUM_SRC = 1 << SEL_W
) (
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] clk_src_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               clk_o
);
    logic [NUM_SRC-1:0] gate;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
        localparam logic RST_VAL = (g == 0);
        logic req;
        logic sync1_q;
        logic sync2_q;
        logic gate_q;

        // Request this lane when selected and every other lane is closed.
        always_comb begin
            req = (sel_i == SEL_W'(g));
            for (int k = 0; k < NUM_SRC; k++) begin
                if (k != g && gate[k]) req = 1'b0;
            end
        end

        // Bring the request into this lane's clock domain.
        always_ff @(posedge clk_src_i[g]) begin
            if (!rst_ni) begin
                sync1_q <= RST_VAL;
                sync2_q <= RST_VAL;
            end else begin
                sync1_q <= req;
                sync2_q <= sync1_q;
            end
        end

        // Update the gate while this lane's clock is low.
        always_ff @(negedge clk_src_i[g]) begin
            if (!rst_ni) gate_q <= RST_VAL;
            else         gate_q <= sync2_q;
        end

        assign gate[g] = gate_q;
    end

    // OR the gated clocks together; at most one gate is open at a time.
    assign clk_o = |(clk_src_i & gate);
endmodule

// File: rtl/ckdiv_counter.sv
// Module: ckdiv_counter
// Period counter with working copies of the divide and compare values.
// The count runs from 0 to the working divide value and wraps to 0. New
// settings are taken only at the wrap, and continuously while disabled.
// Assumes: one clock, already selected upstream; synchronous active-low reset.
module ckdiv_counter #(
    parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] div_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] div_o,
    output logic [CNT_W-1:0] cmp_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] cmp_q;
    logic             wrap;

    // End of the current period.
    assign wrap = (cnt_q == div_q);

    // Advance the count; reload the settings at the wrap or while idle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            div_q <= '0;
            cmp_q <= '0;
        end else if (!en_i || wrap) begin
            cnt_q <= '0;
            div_q <= div_i;
            cmp_q <= cmp_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign div_o = div_q;
    assign cmp_o = cmp_q;
endmodule

// File: rtl/ckdiv_shaper.sv
// Module: ckdiv_shaper
// Turns the counter position into the output waveform. The output is low while
// the count is at or below the compare value and high above it. An invalid
// setting (compare not below divide) forces it low and raises the error flag.
// Both outputs are flops, so the divided clock is free of glitches.
// Assumes: same clock and reset as the counter.
module ckdiv_shaper #(
    parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] div_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             dclk_o,
    output logic             err_o
);
    logic valid;
    logic high_phase;
    logic dclk_q;
    logic err_q;

    // Decode the setting and the phase from the working values.
    assign valid      = (cmp_i < div_i);
    assign high_phase = (cnt_i > cmp_i);

    // Register the waveform and the error flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dclk_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            dclk_q <= en_i && valid && high_phase;
            err_q  <= en_i && !valid;
        end
    end

    assign dclk_o = dclk_q;
    assign err_o  = err_q;
endmodule

// File: rtl/clkdiv_duty.sv
// Module: clkdiv_duty (top)
// Divides a selected source clock by (divide+1). The low phase lasts
// (compare+1) source cycles. A glitch-free switch feeds the selected clock to
// the counter and the shaper.
// Assumes: source select changes while the divider is disabled, or the caller
// accepts one irregular period around a switch.
module clkdiv_duty #(
    parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W,
    parameter int unsigned SEL_W = clkdiv_pkg::DEF_SEL_W
) (
    input  logic             rst_ni,
    input  logic             pclk_i,
    input  logic             fclk_i,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [CNT_W-1:0] div_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             dclk_o,
    output logic             cfg_err_o
);
    localparam int unsigned NUM_SRC = 1 << SEL_W;

    logic [NUM_SRC-1:0] src_vec;
    logic               src_clk;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   div_act;
    logic [CNT_W-1:0]   cmp_act;

    // Place the sources at their select codes.
    always_comb begin
        src_vec = '0;
        src_vec[clkdiv_pkg::SRC_PCLK] = pclk_i;
        src_vec[clkdiv_pkg::SRC_FCLK] = fclk_i;
    end

    ckdiv_srcsel #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) u_srcsel (
        .rst_ni    (rst_ni),
        .clk_src_i (src_vec),
        .sel_i     (sel_i),
        .clk_o     (src_clk)
    );

    ckdiv_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i  (src_clk),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .div_i  (div_i),
        .cmp_i  (cmp_i),
        .cnt_o  (cnt_q),
        .div_o  (div_act),
        .cmp_o  (cmp_act)
    );

    ckdiv_shaper #(.CNT_W(CNT_W)) u_shaper (
        .clk_i  (src_clk),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .cnt_i  (cnt_q),
        .div_i  (div_act),
        .cmp_i  (cmp_act),
        .dclk_o (dclk_o),
        .err_o  (cfg_err_o)
    );
endmodule

// File: rtl/ckdiv_checker.sv
// Module: ckdiv_checker
// Temporal checks on the divider. It is bound into clkdiv_duty and clocked by
// the selected source clock.
module ckdiv_checker #(
    parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W
) (
    input logic             clk,
    input logic             rst_ni,
    input logic             en,
    input logic             dclk,
    input logic             err,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] div_act
);
    // R5: disabled at an edge means the output is low after it.
    p_low_when_off_r5: assert property (@(posedge clk) disable iff (!rst_ni)
        !en |=> !dclk);

    // R5: disabled at an edge means the counter is at zero after it.
    p_cnt_zero_off_r5: assert property (@(posedge clk) disable iff (!rst_ni)
        !en |=> (cnt == '0));

    // R6: a raised error flag never coincides with a high output.
    p_err_low_r6: assert property (@(posedge clk) disable iff (!rst_ni)
        err |-> !dclk);

    // R2: the counter never passes the working divide value.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_ni)
        cnt <= div_act);

    // R2: the counter returns to zero after the last count of a period.
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_ni)
        (en && cnt == div_act) |=> (cnt == '0));

    // R7: the working divide value holds in the middle of a running period.
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
        (en && cnt != div_act) |=> $stable(div_act));
endmodule

bind clkdiv_duty ckdiv_checker #(.CNT_W(CNT_W)) u_checker (
    .clk     (src_clk),
    .rst_ni  (rst_ni),
    .en      (en_i),
    .dclk    (dclk_o),
    .err     (cfg_err_o),
    .cnt     (cnt_q),
    .div_act (div_act)
);

// File: tb/test_clkdiv_duty.sv
// Bench for clkdiv_duty. A behavioural model steps on the selected source
// clock, and its output is compared with the design after every source edge.
module test_clkdiv_duty;
    localparam int CLK_PERIOD  = 10;
    localparam int FCLK_PERIOD = 14;

    logic       rst_ni = 1'b0;
    logic       pclk   = 1'b0;
    logic       fclk   = 1'b0;
    logic       en     = 1'b0;
    logic       sel    = 1'b0;
    logic [3:0] div    = 4'd0;
    logic [3:0] cmp    = 4'd0;
    logic       dclk;
    logic       err;

    int    checks   = 0;
    int    failures = 0;
    bit    done     = 1'b0;
    bit    armed    = 1'b0;
    string tag      = "R1";

    // Model state, all plain integers.
    int m_cnt = 0, m_div = 0, m_cmp = 0, m_out = 0, m_err = 0;

    always #(CLK_PERIOD/2)  pclk = ~pclk;
    always #(FCLK_PERIOD/2) fclk = ~fclk;

    clkdiv_duty i_clkdiv_duty (
        .rst_ni    (rst_ni),
        .pclk_i    (pclk),
        .fclk_i    (fclk),
        .en_i      (en),
        .sel_i     (sel),
        .div_i     (div),
        .cmp_i     (cmp),
        .dclk_o    (dclk),
        .cfg_err_o (err)
    );

    task automatic model_step();
        int n_out, n_err;
        if (!rst_ni) begin
            m_cnt = 0; m_div = 0; m_cmp = 0; m_out = 0; m_err = 0;
        end else if (!en) begin
            m_cnt = 0; m_div = div; m_cmp = cmp; m_out = 0; m_err = 0;
        end else begin
            n_out = (m_cmp < m_div && m_cnt > m_cmp) ? 1 : 0;
            n_err = (m_cmp < m_div) ? 0 : 1;
            if (m_cnt == m_div) begin
                m_cnt = 0; m_div = div; m_cmp = cmp;
            end else begin
                m_cnt = m_cnt + 1;
            end
            m_out = n_out;
            m_err = n_err;
        end
    endtask

    always @(posedge pclk) if (sel == 1'b0) model_step();
    always @(posedge fclk) if (sel == 1'b1) model_step();

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Wait for the selected clock's falling edge and compare with the model.
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            if (sel == 1'b0) @(negedge pclk);
            else             @(negedge fclk);
            if (armed) begin
                check("dclk", int'(dclk), m_out);
                check("err",  int'(err),  m_err);
            end
        end
    endtask

    task automatic run(input string t, input int d, input int c, input int n);
        tag = t;
        div = d[3:0];
        cmp = c[3:0];
        tick(n);
    endtask

    initial begin
        rst_ni = 1'b0;
        tick(8);
        armed = 1'b1;
        tag = "R1";
        tick(1);                          // R1: reset state, both outputs low
        rst_ni = 1'b1;
        tick(4);

        en = 1'b1;
        run("R3", 5, 2, 30);              // R2/R3: period 6, low 3, high 3
        run("R2", 3, 0, 20);              // R2: period 4, low 1
        tick(2);
        run("R7", 9, 6, 1);               // R7: change mid-period
        run("R7", 2, 1, 30);              // R7: change again before the wrap
        run("R3", 15, 14, 40);            // R3: one-cycle high phase
        run("R2", 1, 0, 12);              // R2: smallest valid divide

        tag = "R5";
        div = 4'd7; cmp = 4'd3;
        tick(5);
        en = 1'b0;                        // R5: disable mid-period
        tick(6);
        en = 1'b1;                        // R5: restart with a full low phase
        tick(20);

        run("R6", 4, 4, 12);              // R6: compare equal to divide
        run("R6", 0, 0, 10);              // R6: zero divide
        run("R6", 3, 9, 10);              // R6: compare above divide
        en = 1'b0;
        tick(4);                          // R6: flag drops while disabled

        tag = "R4";
        sel = 1'b1;                       // R4: move to the 48 MHz clock while idle
        tick(20);
        en = 1'b1;
        run("R4", 4, 1, 40);
        run("R4", 6, 3, 30);
        en = 1'b0;
        tick(4);
        sel = 1'b0;                       // R4: back to the bus clock
        tick(20);
        en = 1'b1;
        run("R4", 3, 2, 24);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule